// File: doc/BRIEF.md
# Two-Subphase Address Parity Generator and Checker

This block computes parity for the address phase of a shared-bus request. A request is 37 active-low address lines (address bits 39 down to 3) and 5 active-low request-type lines. They are sent in two sub-phases. Sub-phase 1 carries the physical address. Sub-phase 2 reuses the same lines for transaction-type information. Each sub-phase is covered by two parity lines, and the two coverage groups trade places between sub-phases. The upper address group is bits 39..24. The lower group is bits 23..3 together with the five request lines. Parity is defined on electrical levels: a parity line is high when an even number of its covered lines are low.

Strobe capture happens upstream. By the time the address strobe is presented, the lines of both sub-phases are already available. At the strobe, the requestor side registers the four parity lines and drives them on the next clock. The receiver side records what it expects at the same strobe. One clock later it compares the received parity lines and produces a one-cycle error flag for each parity bit in each sub-phase that mismatches.

Top module: `addr_par_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `tx_par1_n` = 2'b11, `tx_par2_n` = 2'b11, `tx_vld` = 0, `err1` = 2'b00 and `err2` = 2'b00.
- R2: Sub-phase 1 coverage: bit [0] of the sub-phase-1 parity covers address bits 39..24, which are `sp1_adr_n[36:21]`. Bit [1] covers address bits 23..3 (`sp1_adr_n[20:0]`) plus all five `sp1_req_n` lines. Index i of an address bus is address bit i+3.
- R3: Sub-phase 2 coverage is swapped: bit [1] covers `sp2_adr_n[36:21]`, and bit [0] covers `sp2_adr_n[20:0]` plus `sp2_req_n`.
- R4: A parity line is 1 (electrically high) when an even number of its covered lines are 0, and 0 when that count is odd. When all covered lines are 1, both parity lines are 1.
- R5: When `ads` is high at a clock edge, `tx_par1_n`, `tx_par2_n` and a one-cycle `tx_vld` appear in the cycle after that edge. When `ads` is low, `tx_vld` is 0 and the parity outputs hold their last values.
- R6: After a strobe at edge E0, `rx_par1_n` and `rx_par2_n` are sampled at edge E1. Each of `err1` and `err2` is then set, in the cycle after E1, to the bitwise difference between the received and the expected parity (1 = mismatch).
- R7: Strobes at consecutive edges are each checked against their own captured lines, with no mixing between requests.
- R8: Received parity values that do not follow a strobe by exactly one edge are ignored: `err1` and `err2` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ads | input | 1 | Address strobe, high for one cycle per new request |
| sp1_adr_n | input | 37 | Sub-phase 1 address lines, electrical levels, index i = address bit i+3 |
| sp1_req_n | input | 5 | Sub-phase 1 request-type lines, electrical levels |
| sp2_adr_n | input | 37 | Sub-phase 2 lines on the address pins, electrical levels |
| sp2_req_n | input | 5 | Sub-phase 2 request-type lines, electrical levels |
| rx_par1_n | input | 2 | Received sub-phase 1 parity lines |
| rx_par2_n | input | 2 | Received sub-phase 2 parity lines |
| tx_par1_n | output | 2 | Generated sub-phase 1 parity lines |
| tx_par2_n | output | 2 | Generated sub-phase 2 parity lines |
| tx_vld | output | 1 | High in the cycle in which newly generated parity is driven |
| err1 | output | 2 | Sub-phase 1 mismatch flag, one per parity bit |
| err2 | output | 2 | Sub-phase 2 mismatch flag, one per parity bit |

## Verification
On every cycle, the assertions check the reset state and the one-clock timing of the generated parity, including that it holds between strobes. They also check that each error flag equals the difference between the received parity and the parity driven one clock earlier, and that no error appears without a strobe two edges before. They also confirm that all-high lines produce high parity. Which lines fall into which group in each sub-phase, and whether the level rule is correct for random patterns, can only be shown by the bench scenarios. These include single low lines placed in each group, randomly corrupted parity, and back-to-back strobes.

// File: rtl/apar_pkg.sv
package apar_pkg;
  // Default geometry of the covered lines
  localparam int ADDR_MSB_D  = 39;
  localparam int ADDR_LSB_D  = 3;
  localparam int SPLIT_BIT_D = 24;
  localparam int REQ_W_D     = 5;

  typedef logic [1:0] par_pair_t;

  // Mismatch between a received and an expected parity pair (1 = bad bit)
  function automatic par_pair_t pair_diff(input par_pair_t rcv, input par_pair_t exp);
    return rcv ^ exp;
  endfunction

  // Coverage swap: position 0 gets the upper group unless swapped
  function automatic par_pair_t place_groups(input logic up_lvl, input logic lo_lvl,
                                             input bit swap);
    return swap ? {up_lvl, lo_lvl} : {lo_lvl, up_lvl};
  endfunction
endpackage

// File: rtl/apar_level.sv
module apar_level #(
  parameter int W = 16
) (
  input  logic [W-1:0] lines_n,
  output logic         par_n
);
  // Odd count of low lines drives the parity line low
  logic odd_lows;
  assign odd_lows = ^(~lines_n);
  assign par_n    = ~odd_lows;
endmodule

// File: rtl/apar_coverage.sv
module apar_coverage
  import apar_pkg::*;
#(
  parameter int A_W   = 37,
  parameter int UP_W  = 16,
  parameter int REQ_W = 5,
  parameter bit SWAP  = 1'b0
) (
  input  logic [A_W-1:0]   adr_n,
  input  logic [REQ_W-1:0] req_n,
  output par_pair_t        par_n
);
  localparam int LO_A_W = A_W - UP_W;
  localparam int LO_W   = LO_A_W + REQ_W;

  logic [UP_W-1:0] up_grp;
  logic [LO_W-1:0] lo_grp;
  logic            up_lvl;
  logic            lo_lvl;

  assign up_grp = adr_n[A_W-1 -: UP_W];
  assign lo_grp = {req_n, adr_n[LO_A_W-1:0]};

  apar_level #(.W(UP_W)) u_up (.lines_n(up_grp), .par_n(up_lvl));
  apar_level #(.W(LO_W)) u_lo (.lines_n(lo_grp), .par_n(lo_lvl));

  assign par_n = place_groups(up_lvl, lo_lvl, SWAP);
endmodule

// File: rtl/apar_rx_check.sv
module apar_rx_check
  import apar_pkg::*;
#(
  parameter int A_W         = 37,
  parameter int UP_W        = 16,
  parameter int REQ_W       = 5,
  parameter bit STORE_LINES = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [A_W-1:0]   sp1_adr_n,
  input  logic [REQ_W-1:0] sp1_req_n,
  input  logic [A_W-1:0]   sp2_adr_n,
  input  logic [REQ_W-1:0] sp2_req_n,
  input  par_pair_t        rx1_n,
  input  par_pair_t        rx2_n,
  output logic             pend,
  output par_pair_t        err1,
  output par_pair_t        err2
);
  par_pair_t exp1, exp2;

  generate
    if (STORE_LINES) begin : g_lines
      // Keep the raw lines, compute parity during the compare cycle
      logic [A_W-1:0]   a1_q, a2_q;
      logic [REQ_W-1:0] r1_q, r2_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          a1_q <= '1; a2_q <= '1; r1_q <= '1; r2_q <= '1;
        end else if (cap) begin
          a1_q <= sp1_adr_n; a2_q <= sp2_adr_n;
          r1_q <= sp1_req_n; r2_q <= sp2_req_n;
        end
      end
      apar_coverage #(.A_W(A_W), .UP_W(UP_W), .REQ_W(REQ_W), .SWAP(1'b0))
        u_c1 (.adr_n(a1_q), .req_n(r1_q), .par_n(exp1));
      apar_coverage #(.A_W(A_W), .UP_W(UP_W), .REQ_W(REQ_W), .SWAP(1'b1))
        u_c2 (.adr_n(a2_q), .req_n(r2_q), .par_n(exp2));
    end else begin : g_bits
      // Compute at the strobe, keep only four expected bits
      par_pair_t c1, c2;
      par_pair_t e1_q, e2_q;
      apar_coverage #(.A_W(A_W), .UP_W(UP_W), .REQ_W(REQ_W), .SWAP(1'b0))
        u_c1 (.adr_n(sp1_adr_n), .req_n(sp1_req_n), .par_n(c1));
      apar_coverage #(.A_W(A_W), .UP_W(UP_W), .REQ_W(REQ_W), .SWAP(1'b1))
        u_c2 (.adr_n(sp2_adr_n), .req_n(sp2_req_n), .par_n(c2));
      always_ff @(posedge clk) begin
        if (rst) begin
          e1_q <= '1; e2_q <= '1;
        end else if (cap) begin
          e1_q <= c1; e2_q <= c2;
        end
      end
      assign exp1 = e1_q;
      assign exp2 = e2_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      err1 <= '0;
      err2 <= '0;
    end else begin
      pend <= cap;
      err1 <= pend ? pair_diff(rx1_n, exp1) : '0;
      err2 <= pend ? pair_diff(rx2_n, exp2) : '0;
    end
  end
endmodule

// File: rtl/addr_par_unit.sv
module addr_par_unit
  import apar_pkg::*;
#(
  parameter int ADDR_MSB    = ADDR_MSB_D,
  parameter int ADDR_LSB    = ADDR_LSB_D,
  parameter int SPLIT_BIT   = SPLIT_BIT_D,
  parameter int REQ_W       = REQ_W_D,
  parameter bit RX_STORE_LN = 1'b0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           ads,
  input  logic [ADDR_MSB-ADDR_LSB:0]     sp1_adr_n,
  input  logic [REQ_W-1:0]               sp1_req_n,
  input  logic [ADDR_MSB-ADDR_LSB:0]     sp2_adr_n,
  input  logic [REQ_W-1:0]               sp2_req_n,
  input  logic [1:0]                     rx_par1_n,
  input  logic [1:0]                     rx_par2_n,
  output logic [1:0]                     tx_par1_n,
  output logic [1:0]                     tx_par2_n,
  output logic                           tx_vld,
  output logic [1:0]                     err1,
  output logic [1:0]                     err2
);
  localparam int A_W  = ADDR_MSB - ADDR_LSB + 1;
  localparam int UP_W = ADDR_MSB - SPLIT_BIT + 1;
  localparam int NSP  = 2;

  // Named events for the checker
  logic cap_fire;
  logic chk_fire;
  assign cap_fire = ads & ~rst;

  logic [NSP-1:0][A_W-1:0]   adr_bus;
  logic [NSP-1:0][REQ_W-1:0] req_bus;
  par_pair_t                 tx_calc [NSP];
  par_pair_t                 tx_q    [NSP];

  assign adr_bus = {sp2_adr_n, sp1_adr_n};
  assign req_bus = {sp2_req_n, sp1_req_n};

  generate
    for (genvar sp = 0; sp < NSP; sp++) begin : g_tx
      apar_coverage #(.A_W(A_W), .UP_W(UP_W), .REQ_W(REQ_W), .SWAP(sp == 1))
        u_cov (.adr_n(adr_bus[sp]), .req_n(req_bus[sp]), .par_n(tx_calc[sp]));
      always_ff @(posedge clk) begin
        if (rst)           tx_q[sp] <= '1;
        else if (cap_fire) tx_q[sp] <= tx_calc[sp];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) tx_vld <= 1'b0;
    else     tx_vld <= cap_fire;
  end

  assign tx_par1_n = tx_q[0];
  assign tx_par2_n = tx_q[1];

  apar_rx_check #(.A_W(A_W), .UP_W(UP_W), .REQ_W(REQ_W), .STORE_LINES(RX_STORE_LN)) u_rx (
    .clk(clk), .rst(rst), .cap(cap_fire),
    .sp1_adr_n(sp1_adr_n), .sp1_req_n(sp1_req_n),
    .sp2_adr_n(sp2_adr_n), .sp2_req_n(sp2_req_n),
    .rx1_n(rx_par1_n), .rx2_n(rx_par2_n),
    .pend(chk_fire), .err1(err1), .err2(err2)
  );
endmodule

// File: rtl/addr_par_unit_chk.sv
module addr_par_unit_chk #(
  parameter int A_W   = 37,
  parameter int REQ_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             ads,
  input logic [A_W-1:0]   sp1_adr_n,
  input logic [REQ_W-1:0] sp1_req_n,
  input logic [A_W-1:0]   sp2_adr_n,
  input logic [REQ_W-1:0] sp2_req_n,
  input logic [1:0]       rx_par1_n,
  input logic [1:0]       rx_par2_n,
  input logic [1:0]       tx_par1_n,
  input logic [1:0]       tx_par2_n,
  input logic             tx_vld,
  input logic [1:0]       err1,
  input logic [1:0]       err2,
  input logic             cap_fire,
  input logic             chk_fire
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (tx_par1_n == 2'b11 && tx_par2_n == 2'b11 && !tx_vld && err1 == 2'b00 && err2 == 2'b00));

  p_idle_lines_high_r4: assert property (@(posedge clk) disable iff (rst)
    (ads && &sp1_adr_n && &sp1_req_n && &sp2_adr_n && &sp2_req_n)
      |=> (tx_par1_n == 2'b11 && tx_par2_n == 2'b11));

  p_vld_after_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    ads |=> tx_vld);

  p_hold_between_r5: assert property (@(posedge clk) disable iff (rst)
    !ads |=> (!tx_vld && $stable(tx_par1_n) && $stable(tx_par2_n)));

  p_err_is_diff_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(ads) && !$past(rst)) |=>
      (err1 == $past(rx_par1_n ^ tx_par1_n) && err2 == $past(rx_par2_n ^ tx_par2_n)));

  p_check_follows_cap_r7: assert property (@(posedge clk) disable iff (rst)
    cap_fire |=> chk_fire);

  p_no_err_unpaired_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(ads) || $past(rst)) |=> (err1 == 2'b00 && err2 == 2'b00));
endmodule

bind addr_par_unit addr_par_unit_chk #(.A_W(A_W), .REQ_W(REQ_W)) u_chk (
  .clk(clk), .rst(rst), .ads(ads),
  .sp1_adr_n(sp1_adr_n), .sp1_req_n(sp1_req_n),
  .sp2_adr_n(sp2_adr_n), .sp2_req_n(sp2_req_n),
  .rx_par1_n(rx_par1_n), .rx_par2_n(rx_par2_n),
  .tx_par1_n(tx_par1_n), .tx_par2_n(tx_par2_n), .tx_vld(tx_vld),
  .err1(err1), .err2(err2),
  .cap_fire(cap_fire), .chk_fire(chk_fire)
);

// File: tb/addr_par_unit_bench.sv
`timescale 1ns/1ps
module addr_par_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        ads;
  logic [36:0] sp1_adr_n, sp2_adr_n;
  logic [4:0]  sp1_req_n, sp2_req_n;
  logic [1:0]  rx_par1_n, rx_par2_n;
  logic [1:0]  tx_par1_n, tx_par2_n;
  logic        tx_vld;
  logic [1:0]  err1, err2;

  always #2 clk = ~clk;

  addr_par_unit u_addr_par_unit (
    .clk(clk), .rst(rst), .ads(ads),
    .sp1_adr_n(sp1_adr_n), .sp1_req_n(sp1_req_n),
    .sp2_adr_n(sp2_adr_n), .sp2_req_n(sp2_req_n),
    .rx_par1_n(rx_par1_n), .rx_par2_n(rx_par2_n),
    .tx_par1_n(tx_par1_n), .tx_par2_n(tx_par2_n), .tx_vld(tx_vld),
    .err1(err1), .err2(err2)
  );

  int  n_vec  = 0;
  int  n_bad  = 0;
  bit  done   = 1'b0;

  // Bench model state
  logic [3:0] m_tx;        // {par2, par1} expected after next edge
  logic       m_vld;
  logic [3:0] m_err;       // {err2, err1}
  logic       m_last_ads;
  logic [3:0] m_last_exp;

  // Level rule: count low lines, high result when the count is even (R4)
  function automatic logic lvl(input logic [63:0] v, input int w);
    int z = 0;
    for (int i = 0; i < w; i++) if (!v[i]) z++;
    return (z % 2) == 0;
  endfunction

  // Coverage per sub-phase (R2, R3)
  function automatic logic [1:0] cov(input bit sp2, input logic [36:0] a, input logic [4:0] r);
    logic hi, lo;
    hi = lvl({48'b0, a[36:21]}, 16);
    lo = lvl({38'b0, r, a[20:0]}, 26);
    return sp2 ? {hi, lo} : {lo, hi};
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle: check what the last edge produced, then drive the next
  task automatic step(input bit a, input logic [36:0] a1, input logic [4:0] r1,
                      input logic [36:0] a2, input logic [4:0] r2, input logic [3:0] mask);
    logic [3:0] e;
    logic [3:0] rx;
    check("R2/R3/R4/R5 tx parity", {tx_par2_n, tx_par1_n}, m_tx);
    check("R5 tx_vld", {3'b0, tx_vld}, {3'b0, m_vld});
    check("R6/R7/R8 err", {err2, err1}, m_err);
    if (m_last_ads) rx = m_last_exp ^ mask;
    else            rx = 4'($urandom);
    rx_par1_n = rx[1:0];
    rx_par2_n = rx[3:2];
    ads = a; sp1_adr_n = a1; sp1_req_n = r1; sp2_adr_n = a2; sp2_req_n = r2;
    e = {cov(1'b1, a2, r2), cov(1'b0, a1, r1)};
    m_err      = m_last_ads ? mask : 4'b0;   // R8 when no strobe precedes
    if (a) m_tx = e;
    m_vld      = a;
    m_last_ads = a;
    m_last_exp = e;
    @(negedge clk);
  endtask

  function automatic logic [36:0] rnd37();
    return {5'($urandom), $urandom};
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    rst = 1'b1; ads = 1'b1;
    sp1_adr_n = '0; sp2_adr_n = '0; sp1_req_n = '0; sp2_req_n = '0;
    rx_par1_n = 2'b00; rx_par2_n = 2'b00;
    repeat (3) @(negedge clk);
    // R1: reset state, strobe during reset ignored
    check("R1 tx parity", {tx_par2_n, tx_par1_n}, 4'hF);
    check("R1 tx_vld", {3'b0, tx_vld}, 4'h0);
    check("R1 err", {err2, err1}, 4'h0);
    rst = 1'b0; ads = 1'b0;
    m_tx = 4'hF; m_vld = 1'b0; m_err = 4'h0; m_last_ads = 1'b0; m_last_exp = 4'hF;
    @(negedge clk);

    // R4: all lines high gives high parity
    step(1, '1, '1, '1, '1, 4'h0);
    // R2: one low upper line in sub-phase 1 -> par1[0] low
    step(1, ~(37'd1 << 30), '1, '1, '1, 4'h0);
    // R2: one low request line in sub-phase 1 -> par1[1] low
    step(1, '1, 5'b11110, '1, '1, 4'h0);
    // R3: one low lower address line in sub-phase 2 -> par2[0] low
    step(1, '1, '1, ~(37'd1 << 4), '1, 4'h0);
    // R3: one low upper line in sub-phase 2 -> par2[1] low
    step(1, '1, '1, ~(37'd1 << 36), '1, 4'h5);
    // R7: back-to-back with distinct corruption masks
    step(1, rnd37(), 5'($urandom), rnd37(), 5'($urandom), 4'hA);
    step(1, rnd37(), 5'($urandom), rnd37(), 5'($urandom), 4'h3);
    step(0, rnd37(), 5'($urandom), rnd37(), 5'($urandom), 4'hC);
    // R8: received parity with no strobe is ignored
    step(0, rnd37(), 5'($urandom), rnd37(), 5'($urandom), 4'hF);
    step(0, rnd37(), 5'($urandom), rnd37(), 5'($urandom), 4'hF);

    for (int k = 0; k < 3000; k++) begin
      bit a = ($urandom % 10) < 6;
      logic [3:0] mk = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      step(a, rnd37(), 5'($urandom), rnd37(), 5'($urandom), mk);
    end
    step(0, '1, '1, '1, '1, 4'h0);
    step(0, '1, '1, '1, '1, 4'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule